// File: doc/BRIEF.md
# Character Display Host Bus Port

This block is the host-facing port of a character display controller. A host drives a register-select line, a read/write line and an enable strobe, and it moves bytes over a data bus that runs either 8 or 4 bits wide. The port turns each strobe into one of four operations: command write, status read, data write or data read. Commands go to a decoder outside the block. Data writes and RAM prefetches go to the display memory through request/acknowledge pairs.

The strobe is asynchronous to the system clock. A short synchronizer detects its falling edge. The select, direction and bus values are latched while the strobe is high and used when it falls. In narrow mode every byte takes two strobes, upper half first. The port watches accepted commands for the width-select command and switches modes itself.

Reads of display data come from a one-byte holding register. That register is refilled from memory after each host read and whenever the core reports an address-set or cursor-shift. If the host moves the address by any other means, its next read still returns the old holding value. Only the read after that one returns the new contents.

Top module: `chr_host_port`

## Requirements
- R1: The two select bits pick the operation as {reg_sel_i, read_i}: 00 is a command write, 01 a status read, 10 a data write and 11 a data read. An accepted command raises cmd_wr_o for one cycle with the received byte on cmd_byte_o.
- R2: A status read returns the busy flag on bit 7 and addr_ctr_i on bits 6..0. The busy flag is core_busy_i OR a pending write request OR a pending fetch request.
- R3: In narrow mode only bus bits 7..4 carry data, and bits 3..0 are ignored. A byte is sent upper nibble first and lower nibble second. On reads, the selected nibble is driven on bits 7..4 and bits 3..0 read zero.
- R4: A command whose bits 7..5 equal 001 sets the width from bit 4: 1 selects 8-bit and 0 selects 4-bit. After reset the width is 8-bit.
- R5: In narrow mode a command or data write takes effect only after its second nibble. The first nibble produces no cmd_wr_o, no wr_req_o and no err_o.
- R6: An accepted data write loads the holding register. wr_req_o then stays high, with wr_data_o equal to the written byte, until wr_ack_i is seen.
- R7: A data read returns the holding register. Afterwards fetch_req_o rises and stays high until fetch_ack_i, which loads fetch_data_i into the holding register.
- R8: A pulse on addr_set_i triggers a refill. If the memory contents change without such a pulse, the next data read returns the previous holding value, and the read after it returns the new value.
- R9: A command or data write that completes while the busy flag is 1 is discarded. In its place err_o pulses for exactly one cycle.
- R10: bus_oe_o is high only while strobe_i and read_i are both high.
- R11: Reset returns the nibble phase to the upper half and the width to 8-bit. A half-received byte from before reset is dropped.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Register select: 0 command/status, 1 data |
| read_i | input | 1 | Direction: 1 read, 0 write |
| strobe_i | input | 1 | Asynchronous enable strobe; the transfer completes on its fall |
| bus_i | input | 8 | Data bus from host |
| bus_o | output | 8 | Data bus to host |
| bus_oe_o | output | 1 | Drive enable for bus_o |
| core_busy_i | input | 1 | Core still executing a command |
| addr_ctr_i | input | 7 | Current address counter |
| addr_set_i | input | 1 | Pulse: address set or cursor shift done, refill holding register |
| cmd_wr_o | output | 1 | One-cycle command strobe |
| cmd_byte_o | output | 8 | Command byte |
| wr_req_o | output | 1 | Data write request to memory |
| wr_ack_i | input | 1 | Data write acknowledge |
| wr_data_o | output | 8 | Byte to write |
| fetch_req_o | output | 1 | Prefetch request to memory |
| fetch_ack_i | input | 1 | Prefetch acknowledge, data valid |
| fetch_data_i | input | 8 | Prefetched byte |
| err_o | output | 1 | One-cycle pulse on a write dropped while busy |

## Verification
The four select combinations are driven in wide mode from a vector table. Comparing the command byte, the write data and the returned status or data byte shows whether the routing is correct. Narrow mode is checked with nibble pairs whose lower bus bits carry noise. This separates correct upper-first assembly from swapped, wide or noise-sensitive assembly, and the first nibble is also checked to trigger nothing. Repeated data reads against a moving memory model, with and without the address-set pulse, separate a refill-after-read holding register from one that reads through. Writes made while the core is busy, or while a write is still unacknowledged, show whether the busy OR is formed and whether dropped writes raise only the error pulse.

// File: rtl/chr_host_port_pkg.sv
package chr_host_port_pkg;

  typedef enum logic [1:0] {
    OP_CMD_WR  = 2'b00,
    OP_STAT_RD = 2'b01,
    OP_DATA_WR = 2'b10,
    OP_DATA_RD = 2'b11
  } host_op_e;

  localparam int WIDTH_SEL_BIT = 4;

  function automatic logic is_width_cmd(input logic [7:0] b);
    return (b[7:5] == 3'b001);
  endfunction

endpackage

// File: rtl/chr_strobe_sync.sv
module chr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= strobe_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= 1'b0;
      else        pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign fall_o  = pipe_q[STAGES] & ~pipe_q[STAGES-1];

  // R1: each strobe edge is reported once
  p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/chr_nibble_asm.sv
module chr_nibble_asm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              phase_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0]  hold_q,  hold_n;
  logic              phase_q, phase_n;
  logic              wide_d_q;
  logic              done_q,  done_n;
  logic [DATA_W-1:0] word_q,  word_n;

  always_comb begin
    hold_n  = hold_q;
    phase_n = phase_q;
    done_n  = 1'b0;
    word_n  = word_q;
    if (xfer_i) begin
      if (wide_i) begin
        done_n  = 1'b1;
        word_n  = word_i;
        phase_n = 1'b0;
      end else if (!phase_q) begin
        hold_n  = word_i[DATA_W-1 -: NIB_W];
        phase_n = 1'b1;
      end else begin
        done_n  = 1'b1;
        word_n  = {hold_q, word_i[DATA_W-1 -: NIB_W]};
        phase_n = 1'b0;
      end
    end else if (wide_i != wide_d_q) begin
      phase_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      phase_q  <= 1'b0;
      wide_d_q <= 1'b1;
      done_q   <= 1'b0;
      word_q   <= '0;
    end else begin
      hold_q   <= hold_n;
      phase_q  <= phase_n;
      wide_d_q <= wide_i;
      done_q   <= done_n;
      word_q   <= word_n;
    end
  end

  assign done_o  = done_q;
  assign word_o  = word_q;
  assign phase_o = phase_q;

  // R3: wide mode never sits in the lower-nibble phase
  p_upper_in_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_i && wide_d_q) |-> !phase_q);
  // R5: a completed byte always follows a bus transfer
  p_done_after_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(xfer_i));

endmodule

// File: rtl/chr_data_reg.sv
module chr_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              rd_done_i,
  input  logic              addr_set_i,
  input  logic              wr_ack_i,
  input  logic              fetch_ack_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic [DATA_W-1:0] dreg_o,
  output logic              wr_req_o,
  output logic              fetch_req_o
);
  logic [DATA_W-1:0] dreg_q, dreg_n;
  logic              wr_q,   wr_n;
  logic              fet_q,  fet_n;

  always_comb begin
    dreg_n = dreg_q;
    wr_n   = wr_q;
    fet_n  = fet_q;
    if (wr_load_i) begin
      dreg_n = wr_byte_i;
      wr_n   = 1'b1;
    end else begin
      if (wr_ack_i) wr_n = 1'b0;
      if (fet_q && fetch_ack_i) dreg_n = fetch_data_i;
    end
    if (rd_done_i || addr_set_i) fet_n = 1'b1;
    else if (fetch_ack_i)        fet_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      wr_q   <= 1'b0;
      fet_q  <= 1'b0;
    end else begin
      dreg_q <= dreg_n;
      wr_q   <= wr_n;
      fet_q  <= fet_n;
    end
  end

  assign dreg_o      = dreg_q;
  assign wr_req_o    = wr_q;
  assign fetch_req_o = fet_q;

  // R6: a write request is held until acknowledged
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_ack_i) |=> wr_q);
  // R7: a fetch request is held until acknowledged
  p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_q && !fetch_ack_i) |=> fet_q);

endmodule

// File: rtl/chr_host_port.sv
module chr_host_port
  import chr_host_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel_i,
  input  logic              read_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  input  logic              core_busy_i,
  input  logic [ADDR_W-1:0] addr_ctr_i,
  input  logic              addr_set_i,
  output logic              cmd_wr_o,
  output logic [DATA_W-1:0] cmd_byte_o,
  output logic              wr_req_o,
  input  logic              wr_ack_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              fetch_req_o,
  input  logic              fetch_ack_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              err_o
);
  localparam int NIB_W = DATA_W / 2;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic strobe_hi, strobe_fall;
  chr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .strobe_i (strobe_i),
    .level_o  (strobe_hi),
    .fall_o   (strobe_fall)
  );

  // capture the host lines while the strobe is high
  logic              cap_sel_q, cap_rd_q;
  logic [DATA_W-1:0] cap_bus_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cap_sel_q <= 1'b0;
      cap_rd_q  <= 1'b0;
      cap_bus_q <= '0;
    end else if (strobe_hi) begin
      cap_sel_q <= reg_sel_i;
      cap_rd_q  <= read_i;
      cap_bus_q <= bus_i;
    end
  end

  logic              wide_q, wide_n;
  logic              done;
  logic [DATA_W-1:0] word;
  logic              phase;
  chr_nibble_asm #(.DATA_W(DATA_W)) u_nib (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .xfer_i  (strobe_fall),
    .wide_i  (wide_q),
    .word_i  (cap_bus_q),
    .done_o  (done),
    .word_o  (word),
    .phase_o (phase)
  );

  host_op_e op;
  assign op = host_op_e'({cap_sel_q, cap_rd_q});

  logic busy_flag;
  logic wr_load, rd_done;
  logic [DATA_W-1:0] dreg;
  assign busy_flag = core_busy_i | wr_req_o | fetch_req_o;
  assign wr_load   = done && (op == OP_DATA_WR) && !busy_flag;
  assign rd_done   = done && (op == OP_DATA_RD);

  chr_data_reg #(.DATA_W(DATA_W)) u_dreg (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .wr_load_i    (wr_load),
    .wr_byte_i    (word),
    .rd_done_i    (rd_done),
    .addr_set_i   (addr_set_i),
    .wr_ack_i     (wr_ack_i),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_data_i (fetch_data_i),
    .dreg_o       (dreg),
    .wr_req_o     (wr_req_o),
    .fetch_req_o  (fetch_req_o)
  );
  assign wr_data_o = dreg;

  // command path and error pulse
  logic              cmd_wr_q, cmd_wr_n;
  logic [DATA_W-1:0] cmd_byte_q, cmd_byte_n;
  logic              err_q, err_n;

  always_comb begin
    cmd_wr_n   = 1'b0;
    cmd_byte_n = cmd_byte_q;
    err_n      = 1'b0;
    wide_n     = wide_q;
    if (done) begin
      unique case (op)
        OP_CMD_WR: begin
          if (busy_flag) begin
            err_n = 1'b1;
          end else begin
            cmd_wr_n   = 1'b1;
            cmd_byte_n = word;
            if (is_width_cmd(word)) wide_n = word[WIDTH_SEL_BIT];
          end
        end
        OP_DATA_WR: if (busy_flag) err_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd_wr_q   <= 1'b0;
      cmd_byte_q <= '0;
      err_q      <= 1'b0;
      wide_q     <= 1'b1;
    end else begin
      cmd_wr_q   <= cmd_wr_n;
      cmd_byte_q <= cmd_byte_n;
      err_q      <= err_n;
      wide_q     <= wide_n;
    end
  end

  assign cmd_wr_o   = cmd_wr_q;
  assign cmd_byte_o = cmd_byte_q;
  assign err_o      = err_q;

  // read return path
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = reg_sel_i ? dreg : {busy_flag, addr_ctr_i};
    if (wide_q)     bus_o = rd_word;
    else if (phase) bus_o = {rd_word[NIB_W-1:0], {NIB_W{1'b0}}};
    else            bus_o = {rd_word[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end
  assign bus_oe_o = strobe_i & read_i;

  // R9: error is a single-cycle pulse
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_o |=> !err_o);
  // R9: a dropped write never also issues a command
  p_err_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(cmd_wr_o && err_o));

endmodule

// File: tb/chr_host_port_tb_top.sv
module chr_host_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel_i, read_i, strobe_i;
  logic [7:0] bus_i, bus_o;
  logic       bus_oe_o;
  logic       core_busy_i;
  logic [6:0] addr_ctr_i;
  logic       addr_set_i;
  logic       cmd_wr_o;
  logic [7:0] cmd_byte_o;
  logic       wr_req_o, wr_ack_i;
  logic [7:0] wr_data_o;
  logic       fetch_req_o, fetch_ack_i;
  logic [7:0] fetch_data_i;
  logic       err_o;

  always #10 clk = ~clk;

  chr_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel_i(reg_sel_i), .read_i(read_i),
    .strobe_i(strobe_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .core_busy_i(core_busy_i), .addr_ctr_i(addr_ctr_i), .addr_set_i(addr_set_i),
    .cmd_wr_o(cmd_wr_o), .cmd_byte_o(cmd_byte_o), .wr_req_o(wr_req_o),
    .wr_ack_i(wr_ack_i), .wr_data_o(wr_data_o), .fetch_req_o(fetch_req_o),
    .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i), .err_o(err_o)
  );

  int   n_chk = 0, n_fail = 0;
  int   cmd_cnt = 0, wr_cnt = 0, err_cnt = 0;
  logic [7:0] cmd_last, wr_last;
  logic       wr_hold = 1'b0;
  logic       done_flag = 1'b0;

  // memory-side model and output monitors
  always @(posedge clk) begin
    wr_ack_i    <= wr_req_o && !wr_ack_i && !wr_hold;
    fetch_ack_i <= fetch_req_o && !fetch_ack_i;
    if (fetch_ack_i) fetch_data_i <= fetch_data_i + 8'd1;
    if (cmd_wr_o) begin cmd_cnt <= cmd_cnt + 1; cmd_last <= cmd_byte_o; end
    if (wr_req_o && wr_ack_i) begin wr_cnt <= wr_cnt + 1; wr_last <= wr_data_o; end
    if (err_o) err_cnt <= err_cnt + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                      output logic [7:0] seen, output logic oe_hi);
    @(negedge clk);
    reg_sel_i = rs; read_i = rw; bus_i = d;
    @(negedge clk);
    strobe_i = 1'b1;
    repeat (4) @(negedge clk);
    seen = bus_o; oe_hi = bus_oe_o;
    strobe_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {rs, rw, bus value, expected}
  localparam logic [17:0] VEC [0:5] = '{
    {1'b0, 1'b0, 8'h01, 8'h01},
    {1'b0, 1'b1, 8'h00, 8'h2A},
    {1'b1, 1'b0, 8'h5A, 8'h5A},
    {1'b1, 1'b1, 8'h00, 8'h5A},
    {1'b0, 1'b0, 8'h38, 8'h38},
    {1'b0, 1'b1, 8'hFF, 8'h2A}
  };

  initial begin
    logic [7:0] s; logic oe;
    int c0, w0, e0;
    rst_n = 1'b0; reg_sel_i = 0; read_i = 0; strobe_i = 0; bus_i = 0;
    core_busy_i = 0; addr_ctr_i = 7'h2A; addr_set_i = 0; fetch_data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R10 reset oe", {7'b0, bus_oe_o}, 8'h00);
    check("R6 reset wr_req", {7'b0, wr_req_o}, 8'h00);
    check("R7 reset fetch_req", {7'b0, fetch_req_o}, 8'h00);
    check("R9 reset err", {7'b0, err_o}, 8'h00);

    // R1 R2: vector table in wide mode
    for (int i = 0; i < 6; i++) begin
      xfer(VEC[i][17], VEC[i][16], VEC[i][15:8], s, oe);
      case ({VEC[i][17], VEC[i][16]})
        2'b00: check("R1 command byte", cmd_last, VEC[i][7:0]);
        2'b10: check("R1 R6 write data", wr_last, VEC[i][7:0]);
        default: check("R1 R2 read byte", s, VEC[i][7:0]);
      endcase
      check("R10 oe follows read", {7'b0, oe}, {7'b0, VEC[i][16]});
    end
    check("R10 oe low after strobe", {7'b0, bus_oe_o}, 8'h00);

    // R7 R8: prefetch and stale first read
    fetch_data_i = 8'h41;
    @(negedge clk); addr_set_i = 1'b1; @(negedge clk); addr_set_i = 1'b0;
    repeat (6) @(negedge clk);
    xfer(1, 1, 8'h00, s, oe); check("R7 read after addr set", s, 8'h41);
    xfer(1, 1, 8'h00, s, oe); check("R7 refill after read", s, 8'h42);
    fetch_data_i = 8'h70;
    xfer(1, 1, 8'h00, s, oe); check("R8 stale first read", s, 8'h43);
    xfer(1, 1, 8'h00, s, oe); check("R8 second read fresh", s, 8'h70);

    // R9 R2: busy core drops writes
    core_busy_i = 1'b1;
    c0 = cmd_cnt; w0 = wr_cnt; e0 = err_cnt;
    xfer(0, 0, 8'h01, s, oe);
    check("R9 cmd dropped", 8'(cmd_cnt - c0), 8'd0);
    check("R9 err on cmd", 8'(err_cnt - e0), 8'd1);
    xfer(1, 0, 8'h77, s, oe);
    check("R9 data dropped", 8'(wr_cnt - w0), 8'd0);
    check("R9 err on data", 8'(err_cnt - e0), 8'd2);
    xfer(0, 1, 8'h00, s, oe); check("R2 busy bit", s, 8'hAA);
    core_busy_i = 1'b0;

    // R6: write pending keeps busy
    wr_hold = 1'b1;
    xfer(1, 0, 8'h33, s, oe);
    check("R6 wr_req held", {7'b0, wr_req_o}, 8'h01);
    check("R6 wr_data", wr_data_o, 8'h33);
    xfer(0, 1, 8'h00, s, oe); check("R2 R6 busy while pending", s, 8'hAA);
    wr_hold = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 ack clears", {7'b0, wr_req_o}, 8'h00);

    // R4 R3 R5: switch to narrow mode
    xfer(0, 0, 8'h2F, s, oe); check("R4 width cmd", cmd_last, 8'h2F);
    c0 = cmd_cnt; e0 = err_cnt;
    xfer(0, 0, 8'h05, s, oe);
    check("R5 first nibble no cmd", 8'(cmd_cnt - c0), 8'd0);
    check("R5 first nibble no err", 8'(err_cnt - e0), 8'd0);
    xfer(0, 0, 8'hC9, s, oe);
    check("R3 R5 nibble command", cmd_last, 8'h0C);
    w0 = wr_cnt;
    xfer(1, 0, 8'hC5, s, oe);
    check("R5 first nibble no write", 8'(wr_cnt - w0), 8'd0);
    xfer(1, 0, 8'h3A, s, oe);
    check("R3 nibble data write", wr_last, 8'hC3);
    xfer(0, 1, 8'h00, s, oe); check("R3 status upper nibble", s, 8'h20);
    xfer(0, 1, 8'h00, s, oe); check("R3 status lower nibble", s, 8'hA0);

    // R11: reset drops a half byte and restores wide mode
    xfer(0, 0, 8'h70, s, oe);
    do_reset();
    xfer(0, 1, 8'h00, s, oe); check("R11 R4 wide after reset", s, 8'h2A);
    xfer(0, 0, 8'h20, s, oe);
    xfer(0, 0, 8'h00, s, oe);
    xfer(0, 0, 8'h10, s, oe);
    check("R11 phase restarts upper", cmd_last, 8'h01);
    xfer(0, 0, 8'h30, s, oe);
    xfer(0, 0, 8'h00, s, oe);
    xfer(0, 1, 8'h00, s, oe); check("R4 back to wide", s, 8'h2A);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule